// File: doc/BRIEF.md
# Program Memory Read-Path Fault Injector

This block sits between a 16-bit-wide program memory and the CPU that reads it. Instruction fetches use word addresses and byte loads use byte addresses. Both pass through one memory read port. When no fault is armed, the block adds no cycle and changes no bit. The returned word appears in the same cycle a direct connection would deliver it.

A verification environment arms a transient fault with a trigger pulse, a start delay and a window length, all counted in clock cycles. Reads whose request cycle falls inside the window have their returned word altered. The fault can clear one bit, clear a bit and its upper neighbour, or substitute a fixed word. Faults only ever clear bits, except in the fixed-word mode. They are chosen by bit position, so every word read during the window loses the same positions. The stored contents are never changed.

A sticky flag and a saturating counter record the faulted reads. A bench can compare these against its own expected count.

Top module: `pmem_fault_shim`

## Requirements
- R1: Outside a fault window, or with mode 0 (off) latched, `fetchData` equals the memory word read for the request of the previous cycle. `loadData` equals the selected byte of that word. No cycle is added beyond the memory's own one-cycle read latency.
- R2: Mode 1 (single) clears bit `cfgBit` of the returned word and leaves every other bit as read. A targeted bit that already reads 0 stays 0.
- R3: Mode 2 (pair) clears bits `cfgBit` and `cfgBit`+1. With `cfgBit` = 15, only bit 15 is cleared.
- R4: Mode 3 (stuck) replaces the returned word with `cfgStuck`, whatever was stored. A faulted byte load returns the selected byte of `cfgStuck`.
- R5: A trigger accepted at clock edge T faults the requests sampled at edges T+1+`cfgDelay` through T+`cfgDelay`+`cfgLen`, and no others. A trigger with `cfgLen` = 0 is not accepted.
- R6: Faults are transient. A read of a previously faulted address after the window returns the original word.
- R7: `cfgTarget` bit 0 enables faulting of fetches, and bit 1 enables faulting of byte loads.
- R8: In a byte load, `loadAddr` bit 0 = 0 selects word bits 7:0 and bit 0 = 1 selects bits 15:8. The mask acts on word bit positions, so a cleared bit 10 appears as bit 2 of a high-byte load.
- R9: A trigger that arrives while a window is pending or running is ignored. Mode, bit, stuck value and target are captured only when a trigger is accepted.
- R10: `faultSeen` is 0 after reset and becomes 1 on the first faulted read, then stays 1. `faultCount` counts faulted reads (requests hit while a mode other than off is latched) and saturates at its maximum value.
- R11: When `loadReq` is high, `memAddr` is `loadAddr` shifted right by one bit; otherwise it is `fetchAddr`. A load wins when both requests are raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| trigger | input | 1 | Arms a fault window when idle |
| cfgMode | input | 2 | 0 off, 1 single bit, 2 adjacent pair, 3 stuck word |
| cfgBit | input | 4 | Lowest cleared bit position |
| cfgStuck | input | 16 | Substitute word for stuck mode |
| cfgTarget | input | 2 | Bit 0 fetches, bit 1 byte loads |
| cfgDelay | input | DW | Cycles from trigger to window start |
| cfgLen | input | DW | Window length in cycles |
| fetchReq | input | 1 | Instruction fetch request |
| fetchAddr | input | AW | Fetch word address |
| fetchData | output | 16 | Returned opcode word |
| loadReq | input | 1 | Byte load request |
| loadAddr | input | AW+1 | Load byte address |
| loadData | output | 8 | Returned byte |
| memAddr | output | AW | Memory word address |
| memRdata | input | 16 | Memory read word, one cycle after address |
| faultSeen | output | 1 | Sticky faulted-read flag |
| faultCount | output | CW | Saturating faulted-read count |

## Verification
The hardest situation to reach from the ports is a trigger that arrives while a window is already running. The bench must also show that new configuration presented with that trigger leaves the running fault unchanged. The stimulus arms a short delayed window and then pulses the trigger with a different mode on a read that falls inside the window. It then checks that every read in the window still follows the first mode and ends on the first schedule. Counter saturation is reached with one window longer than the counter range, filled with back-to-back fetches.

// File: rtl/pmf_pkg.sv
package pmf_pkg;
  localparam int WORD_W = 16;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_BIT   = 2'd1,
    MODE_PAIR  = 2'd2,
    MODE_STUCK = 2'd3
  } faultMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic arm;       // trigger accepted: latch configuration
    logic hitFetch;  // fetch request in this cycle is faulted
    logic hitLoad;   // load request in this cycle is faulted
  } ctrlStrobe_t;
endpackage

// File: rtl/pmf_ctrl.sv
module pmf_ctrl
  import pmf_pkg::*;
#(
  parameter int DW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trigger,
  input  logic [DW-1:0] cfgDelay,
  input  logic [DW-1:0] cfgLen,
  input  logic [1:0]    cfgTarget,
  input  logic          fetchReq,
  input  logic          loadReq,
  output ctrlStrobe_t   strb
);
  localparam logic [DW-1:0] ONE = DW'(1);

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_ACTIVE} winState_e;

  winState_e     state;
  logic [DW-1:0] cnt;
  logic [1:0]    tgtQ;
  logic          armNow;
  logic          active;

  assign armNow = trigger && (state == ST_IDLE) && (cfgLen != '0);
  assign active = (state == ST_ACTIVE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      tgtQ  <= 2'b00;
    end else begin
      case (state)
        ST_IDLE: if (armNow) begin
          tgtQ <= cfgTarget;
          if (cfgDelay == '0) begin
            state <= ST_ACTIVE;
            cnt   <= cfgLen - ONE;
          end else begin
            state <= ST_WAIT;
            cnt   <= cfgDelay - ONE;
          end
        end
        ST_WAIT: if (cnt == '0) begin
          state <= ST_ACTIVE;
          cnt   <= cfgLen - ONE;
        end else begin
          cnt <= cnt - ONE;
        end
        default: if (cnt == '0) begin
          state <= ST_IDLE;
        end else begin
          cnt <= cnt - ONE;
        end
      endcase
    end
  end

  always_comb begin
    strb.arm      = armNow;
    strb.hitFetch = active && tgtQ[0] && fetchReq && !loadReq;
    strb.hitLoad  = active && tgtQ[1] && loadReq;
  end

  // R5: a pending window always proceeds to the active phase, never back to idle
  p_wait_proceeds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT) |=> (state != ST_IDLE));

  // R9: no configuration is accepted while a window is pending or running
  p_arm_only_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE) |-> !strb.arm);

  // R5: faulted requests only occur inside the active phase
  p_hit_in_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.hitFetch || strb.hitLoad) |-> (state == ST_ACTIVE));
endmodule

// File: rtl/pmf_dpath.sv
module pmf_dpath
  import pmf_pkg::*;
#(
  parameter int AW = 8,
  parameter int CW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStrobe_t       strb,
  input  logic [1:0]        cfgMode,
  input  logic [3:0]        cfgBit,
  input  logic [WORD_W-1:0] cfgStuck,
  input  logic [AW-1:0]     fetchAddr,
  input  logic              loadReq,
  input  logic [AW:0]       loadAddr,
  input  logic [WORD_W-1:0] memRdata,
  output logic [AW-1:0]     memAddr,
  output logic [WORD_W-1:0] fetchData,
  output logic [7:0]        loadData,
  output logic              faultSeen,
  output logic [CW-1:0]     faultCount
);
  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

  faultMode_e        modeQ;
  logic [3:0]        bitQ;
  logic [WORD_W-1:0] stuckQ;
  logic              pendFault;
  logic              pendHi;
  logic              pendLoad;
  logic [WORD_W-1:0] clrBits;
  logic [WORD_W-1:0] outWord;
  logic              clearMode;
  logic              countHit;

  assign memAddr   = loadReq ? loadAddr[AW:1] : fetchAddr;
  assign clearMode = (modeQ == MODE_BIT) || (modeQ == MODE_PAIR);
  assign countHit  = (strb.hitFetch || strb.hitLoad) && (modeQ != MODE_OFF);

  // per-position clear: own position, or the one below in pair mode
  for (genvar g = 0; g < WORD_W; g++) begin : g_clr
    if (g == 0) begin : g_lsb
      assign clrBits[g] = clearMode && (bitQ == 4'(g));
    end else begin : g_up
      assign clrBits[g] = (clearMode && (bitQ == 4'(g))) ||
                          ((modeQ == MODE_PAIR) && (bitQ == 4'(g - 1)));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      modeQ      <= MODE_OFF;
      bitQ       <= '0;
      stuckQ     <= '0;
      pendFault  <= 1'b0;
      pendHi     <= 1'b0;
      pendLoad   <= 1'b0;
      faultSeen  <= 1'b0;
      faultCount <= '0;
    end else begin
      if (strb.arm) begin
        modeQ  <= faultMode_e'(cfgMode);
        bitQ   <= cfgBit;
        stuckQ <= cfgStuck;
      end
      pendFault <= strb.hitFetch || strb.hitLoad;
      pendLoad  <= loadReq;
      if (loadReq) pendHi <= loadAddr[0];
      if (countHit) begin
        faultSeen <= 1'b1;
        if (faultCount != CNT_MAX) faultCount <= faultCount + CW'(1);
      end
    end
  end

  always_comb begin
    if (!pendFault)                outWord = memRdata;
    else if (modeQ == MODE_STUCK)  outWord = stuckQ;
    else                           outWord = memRdata & ~clrBits;
  end

  assign fetchData = outWord;
  assign loadData  = pendHi ? outWord[15:8] : outWord[7:0];

  // R1: with no fault pending or mode off latched, the word passes untouched
  p_off_passthrough_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!pendFault || modeQ == MODE_OFF) |-> (fetchData == memRdata));

  // R2: clearing modes never raise a bit
  p_only_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (modeQ != MODE_STUCK) |-> ((fetchData & ~memRdata) == '0));

  // R8: a low-byte load returns word bits 7:0
  p_low_byte_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pendLoad && !pendHi) |-> (loadData == fetchData[7:0]));

  // R10: flag is sticky and consistent with the counter
  p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    faultSeen |=> faultSeen);
  p_count_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (faultCount != '0) |-> faultSeen);
endmodule

// File: rtl/pmem_fault_shim.sv
module pmem_fault_shim
  import pmf_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 10,
  parameter int CW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trigger,
  input  logic [1:0]        cfgMode,
  input  logic [3:0]        cfgBit,
  input  logic [WORD_W-1:0] cfgStuck,
  input  logic [1:0]        cfgTarget,
  input  logic [DW-1:0]     cfgDelay,
  input  logic [DW-1:0]     cfgLen,
  input  logic              fetchReq,
  input  logic [AW-1:0]     fetchAddr,
  output logic [WORD_W-1:0] fetchData,
  input  logic              loadReq,
  input  logic [AW:0]       loadAddr,
  output logic [7:0]        loadData,
  output logic [AW-1:0]     memAddr,
  input  logic [WORD_W-1:0] memRdata,
  output logic              faultSeen,
  output logic [CW-1:0]     faultCount
);
  ctrlStrobe_t strb;

  pmf_ctrl #(.DW(DW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .trigger(trigger),
    .cfgDelay(cfgDelay), .cfgLen(cfgLen), .cfgTarget(cfgTarget),
    .fetchReq(fetchReq), .loadReq(loadReq), .strb(strb)
  );

  pmf_dpath #(.AW(AW), .CW(CW)) u_dpath (
    .clk(clk), .rst_n(rst_n), .strb(strb),
    .cfgMode(cfgMode), .cfgBit(cfgBit), .cfgStuck(cfgStuck),
    .fetchAddr(fetchAddr), .loadReq(loadReq), .loadAddr(loadAddr),
    .memRdata(memRdata), .memAddr(memAddr),
    .fetchData(fetchData), .loadData(loadData),
    .faultSeen(faultSeen), .faultCount(faultCount)
  );
endmodule

// File: tb/pmem_fault_shim_test.sv
`timescale 1ns/1ps
module pmem_fault_shim_test;
  localparam int AW = 8;
  localparam int DW = 10;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          trigger = 1'b0;
  logic [1:0]    cfgMode = 2'd0;
  logic [3:0]    cfgBit = 4'd0;
  logic [15:0]   cfgStuck = 16'h0;
  logic [1:0]    cfgTarget = 2'd0;
  logic [DW-1:0] cfgDelay = '0;
  logic [DW-1:0] cfgLen = '0;
  logic          fetchReq = 1'b0;
  logic [AW-1:0] fetchAddr = '0;
  logic [15:0]   fetchData;
  logic          loadReq = 1'b0;
  logic [AW:0]   loadAddr = '0;
  logic [7:0]    loadData;
  logic [AW-1:0] memAddr;
  logic [15:0]   memRdata = 16'h0;
  logic          faultSeen;
  logic [CW-1:0] faultCount;

  logic [15:0] mem [0:(1<<AW)-1];
  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;
  // bench-side expected configuration and count
  logic [1:0]  eMode = 2'd0;
  logic [3:0]  eBit = 4'd0;
  logic [15:0] eStuck = 16'h0;
  int          eCount = 0;

  always #4 clk = ~clk;

  always_ff @(posedge clk) memRdata <= mem[memAddr];

  pmem_fault_shim #(.AW(AW), .DW(DW), .CW(CW)) uut (.*);

  function automatic logic [15:0] expW(input logic [15:0] w, input bit flt);
    logic [15:0] r;
    r = w;
    if (flt) begin
      case (eMode)
        2'd1: r = w & ~(16'h1 << eBit);
        2'd2: begin
          r = w & ~(16'h1 << eBit);
          if (eBit != 4'd15) r = r & ~(16'h1 << (eBit + 4'd1));
        end
        2'd3: r = eStuck;
        default: r = w;
      endcase
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic noteFault(input bit flt);
    if (flt && eMode != 2'd0 && eCount < 255) eCount++;
  endtask

  // request issued at current negedge, checked at the following negedge
  task automatic doFetch(input logic [AW-1:0] a, input bit flt, input string tag);
    fetchReq = 1'b1; loadReq = 1'b0; fetchAddr = a;
    #1 chk({tag, " R11 memAddr"}, 16'(memAddr), 16'(a));
    @(posedge clk); @(negedge clk);
    fetchReq = 1'b0;
    chk(tag, fetchData, expW(mem[a], flt));
    noteFault(flt);
  endtask

  task automatic doLoad(input logic [AW:0] ba, input bit flt, input string tag);
    logic [15:0] w;
    loadReq = 1'b1; fetchReq = 1'b1; loadAddr = ba;
    #1 chk({tag, " R11 memAddr"}, 16'(memAddr), 16'(ba >> 1));
    @(posedge clk); @(negedge clk);
    loadReq = 1'b0; fetchReq = 1'b0;
    w = expW(mem[ba >> 1], flt);
    chk(tag, 16'(loadData), ba[0] ? 16'(w[15:8]) : 16'(w[7:0]));
    noteFault(flt);
  endtask

  task automatic armFault(input logic [1:0] m, input logic [3:0] b, input logic [15:0] s,
                          input logic [1:0] t, input int d, input int len);
    cfgMode = m; cfgBit = b; cfgStuck = s; cfgTarget = t;
    cfgDelay = DW'(d); cfgLen = DW'(len);
    trigger = 1'b1;
    @(posedge clk); @(negedge clk);
    trigger = 1'b0;
    if (len != 0) begin eMode = m; eBit = b; eStuck = s; end
  endtask

  task automatic testReset();
    chk("R10 reset flag", 16'(faultSeen), 16'h0);
    chk("R10 reset count", 16'(faultCount), 16'h0);
  endtask

  task automatic testPassthrough();
    for (int i = 0; i < 6; i++) doFetch(AW'(i * 37 + 1), 0, "R1 pass fetch");
    doLoad(9'h010, 0, "R8 pass low byte");
    doLoad(9'h011, 0, "R8 pass high byte");
    chk("R1 no count", 16'(faultCount), 16'h0);
  endtask

  task automatic testSingle();
    // delay 2, len 3: reads 2..4 faulted; mem[2] has bit 4 = 0
    armFault(2'd1, 4'd4, 16'h0, 2'b11, 2, 3);
    for (int i = 0; i < 7; i++) doFetch(AW'(i), (i >= 2 && i < 5), "R2 R5 single bit");
    doFetch(AW'(3), 0, "R6 reread after window");
    chk("R10 flag set", 16'(faultSeen), 16'h1);
    chk("R10 count", 16'(faultCount), 16'(eCount));
  endtask

  task automatic testPair();
    armFault(2'd2, 4'd7, 16'h0, 2'b01, 0, 2);
    doFetch(AW'(0), 1, "R3 pair bit7");
    doFetch(AW'(5), 1, "R3 pair bit7");
    doFetch(AW'(5), 0, "R6 after pair");
    armFault(2'd2, 4'd15, 16'h0, 2'b01, 0, 1);
    doFetch(AW'(0), 1, "R3 pair top bit");
  endtask

  task automatic testStuck();
    armFault(2'd3, 4'd0, 16'h2A02, 2'b11, 1, 3);
    doFetch(AW'(9), 0, "R4 before window");
    doFetch(AW'(9), 1, "R4 stuck fetch");
    doLoad(9'h021, 1, "R4 stuck high byte");
    doLoad(9'h020, 1, "R4 stuck low byte");
    doFetch(AW'(9), 0, "R6 after stuck");
  endtask

  task automatic testTarget();
    armFault(2'd1, 4'd10, 16'h0, 2'b10, 0, 4);
    doFetch(AW'(0), 0, "R7 fetch untargeted");
    doLoad(9'h001, 1, "R7 R8 high byte bit10");
    doLoad(9'h000, 1, "R8 low byte untouched");
    doFetch(AW'(0), 0, "R7 fetch untargeted");
    armFault(2'd1, 4'd1, 16'h0, 2'b01, 0, 2);
    doLoad(9'h000, 0, "R7 load untargeted");
    doFetch(AW'(0), 1, "R7 fetch targeted");
  endtask

  task automatic testRetrigger();
    armFault(2'd1, 4'd4, 16'h0, 2'b01, 0, 0);
    for (int i = 0; i < 3; i++) doFetch(AW'(i), 0, "R5 zero length");
    // window delay 1 len 4 single bit0; retrigger with stuck mode at read 1
    armFault(2'd1, 4'd0, 16'h0, 2'b01, 1, 4);
    doFetch(AW'(0), 0, "R9 pre window");
    cfgMode = 2'd3; cfgStuck = 16'h1234; cfgDelay = '0; cfgLen = DW'(20); trigger = 1'b1;
    doFetch(AW'(0), 1, "R9 retrigger ignored");
    trigger = 1'b0;
    for (int i = 2; i < 7; i++) doFetch(AW'(0), (i < 5), "R9 first schedule kept");
    chk("R10 count", 16'(faultCount), 16'(eCount));
  endtask

  task automatic testSaturate();
    armFault(2'd1, 4'd3, 16'h0, 2'b01, 0, 300);
    for (int i = 0; i < 300; i++) doFetch(AW'(i), 1, "R10 long window");
    doFetch(AW'(8), 0, "R5 long window end");
    chk("R10 saturated", 16'(faultCount), 16'hFF);
    chk("R10 flag held", 16'(faultSeen), 16'h1);
  endtask

  initial begin
    for (int i = 0; i < (1 << AW); i++) mem[i] = 16'(i * 40503) ^ 16'h5A5A;
    mem[0] = 16'hFFFF;
    mem[2] = 16'hFFEF;
    mem[5] = 16'h00C0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    testReset();
    testPassthrough();
    testSingle();
    testPair();
    testStuck();
    testTarget();
    testRetrigger();
    testSaturate();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      finished = 1;
      vectors++;
      miscompares++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule